// File: doc/BRIEF.md
# Multichannel TDM Wire Packer

This block gathers a set of parallel sample channels that share one valid strobe and serialises them onto a smaller number of output data wires. It is meant for a downstream datapath that is clocked several times faster than the sample rate, the ratio being the TDM factor. From the channel count and the TDM factor the block derives, at elaboration, how many wires it needs (channel count over TDM factor, rounded up) and how many cycles each wire is busy (channel count over wire count, rounded up). Channels are laid out in order: wire `w` carries channels `w*CYC` up to `w*CYC+CYC-1`.

A free-running slot counter divides time into periods of TDM-factor cycles. A sample set is taken only at the edge where the slot counter reads 0 with `in_valid` high; it is then held for the whole period while the output walks through the slots. In each period the first CYC slots are valid, and the rest are idle. A single slot index, shared by all wires, is driven alongside the data. With one wire that index is the true channel number.

Top module: `tdm_wire_packer`

## Requirements
- R1: The packer drives ceil(NUM_CH/TDM) data wires, each DW bits, and wire `w` occupies bits `[w*DW +: DW]` of `out_data`; the highest wire carries its own channels like every other wire.
- R2: In a period whose sample set was accepted, `out_valid` is high for exactly the first CYC = ceil(NUM_CH/wires) slots of that period.
- R3: In slot `s` of an accepted period, wire `w` carries the held sample of channel `w*CYC+s`, where channel `c` enters on `in_data[c*DW +: DW]`.
- R4: In slots CYC to TDM-1 of a period, `out_valid` is low, and `out_chan` and every wire read zero.
- R5: While `out_valid` is high, `out_chan` equals the slot number 0..CYC-1, one index shared by all wires.
- R6: Inputs are sampled only at the edge where the slot counter is 0; `in_valid` and `in_data` at any other edge have no effect on the outputs.
- R7: If `in_valid` is low at the start of a period, the whole following period is invalid, with all outputs zero.
- R8: A synchronous active-high `rst` returns the slot counter to 0 and forces `out_valid`, `out_chan` and `out_data` to zero on the next cycle. The first sampling edge is the first edge after `rst` falls.
- R9: When wires times CYC exceeds NUM_CH, slots on the last wire with no channel output zero while `out_valid` stays high.
- R10: With a single wire, `out_chan` runs through the true channel numbers 0..NUM_CH-1 in order, one per cycle.
- R11: Output slot `s` of a period appears in the cycle that starts `s+1` edges after the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample set valid, sampled at period start |
| in_data | input | NUM_CH*DW | Channel `c` at `[c*DW +: DW]` |
| out_valid | output | 1 | Slot carries data on all wires |
| out_data | output | NW*DW | Wire `w` at `[w*DW +: DW]` |
| out_chan | output | max(1,clog2(CYC)) | Slot index shared by all wires |

## Verification
The bench runs four configurations: one with idle slots (4 channels, factor 3), one with a padded last wire (5 channels, factor 3), a single-wire case (4, 4) and a unit-factor case (4, 1). Input data changes in every cycle and `in_valid` toggles in the middle of periods. A packer that samples at the wrong slot would therefore show stray data, and one that does not hold its inputs would show data drifting within a period. The bench also checks padded slots, which a design that leaks a neighbouring channel would fill with non-zero data. It checks idle slots, which an off-by-one valid window would mark valid. It asserts reset at a non-zero slot, which a counter that fails to rephase would leave misaligned with the model afterwards.

// File: rtl/tdm_pack_pkg.sv
package tdm_pack_pkg;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int width_of(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/tdm_slot_ctr.sv
module tdm_slot_ctr #(
   parameter int TDM = 3,
   localparam int SW = tdm_pack_pkg::width_of(TDM)
) (
   input  logic          clk,
   input  logic          rst,
   output logic          start,
   output logic [SW-1:0] oslot
);

   localparam logic [SW-1:0] LAST = SW'(TDM - 1);

   generate
      if (TDM == 1) begin : g_unit
         // every edge opens a period; output slot is always zero
         assign start = 1'b1;
         always_ff @(posedge clk) begin
            oslot <= '0;
         end
      end else begin : g_count
         logic [SW-1:0] slot_q;
         assign start = (slot_q == '0);
         always_ff @(posedge clk) begin
            if (rst) begin
               slot_q <= '0;
               oslot  <= LAST;
            end else begin
               slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
               oslot  <= slot_q;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/tdm_sample_bank.sv
module tdm_sample_bank #(
   parameter int NUM_CH = 4,
   parameter int DW     = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   input  logic                 in_valid,
   input  logic [NUM_CH*DW-1:0] in_data,
   output logic                 active,
   output logic [NUM_CH*DW-1:0] hold
);

   logic [DW-1:0] bank [NUM_CH];
   logic          take;

   assign take = start && in_valid;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         always_ff @(posedge clk) begin
            if (rst) begin
               bank[c] <= '0;
            end else if (take) begin
               bank[c] <= in_data[c*DW +: DW];
            end
         end
         assign hold[c*DW +: DW] = bank[c];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
      end else if (start) begin
         active <= in_valid;
      end
   end

endmodule

// File: rtl/tdm_wire_sel.sv
module tdm_wire_sel #(
   parameter int NUM_CH = 4,
   parameter int DW     = 16,
   parameter int CYC    = 2,
   parameter int BASE   = 0,
   parameter int SW     = 2
) (
   input  logic [NUM_CH*DW-1:0] hold,
   input  logic [SW-1:0]        oslot,
   input  logic                 active,
   output logic [DW-1:0]        wdata
);

   logic [DW-1:0] lane [CYC];

   generate
      for (genvar s = 0; s < CYC; s++) begin : g_lane
         if (BASE + s < NUM_CH) begin : g_real
            assign lane[s] = hold[(BASE+s)*DW +: DW];
         end else begin : g_pad
            assign lane[s] = '0;
         end
      end
   endgenerate

   always_comb begin
      wdata = '0;
      if (active) begin
         for (int s = 0; s < CYC; s++) begin
            if (int'(oslot) == s) wdata = lane[s];
         end
      end
   end

endmodule

// File: rtl/tdm_wire_packer.sv
module tdm_wire_packer #(
   parameter int NUM_CH = 4,
   parameter int TDM    = 3,
   parameter int DW     = 16,
   localparam int NW  = tdm_pack_pkg::ceil_div(NUM_CH, TDM),
   localparam int CYC = tdm_pack_pkg::ceil_div(NUM_CH, NW),
   localparam int CW  = tdm_pack_pkg::width_of(CYC),
   localparam int SW  = tdm_pack_pkg::width_of(TDM)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [NUM_CH*DW-1:0] in_data,
   output logic                 out_valid,
   output logic [NW*DW-1:0]     out_data,
   output logic [CW-1:0]        out_chan
);

   generate
      if (NUM_CH < 1 || TDM < 1 || DW < 1) begin : g_bad_param
         $error("tdm_wire_packer: NUM_CH, TDM and DW must be at least 1");
      end
      if (CYC > TDM) begin : g_bad_derive
         $error("tdm_wire_packer: derived cycle count exceeds TDM factor");
      end
   endgenerate

   logic          start;
   logic [SW-1:0] oslot;
   logic          active;
   logic          slot_live;
   logic [NUM_CH*DW-1:0] hold;

   tdm_slot_ctr #(.TDM(TDM)) u_slot (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .oslot (oslot)
   );

   tdm_sample_bank #(.NUM_CH(NUM_CH), .DW(DW)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .in_valid (in_valid),
      .in_data  (in_data),
      .active   (active),
      .hold     (hold)
   );

   assign slot_live = active && (int'(oslot) < CYC);

   generate
      for (genvar w = 0; w < NW; w++) begin : g_wire
         tdm_wire_sel #(
            .NUM_CH (NUM_CH),
            .DW     (DW),
            .CYC    (CYC),
            .BASE   (w * CYC),
            .SW     (SW)
         ) u_sel (
            .hold   (hold),
            .oslot  (oslot),
            .active (slot_live),
            .wdata  (out_data[w*DW +: DW])
         );
      end
   endgenerate

   assign out_valid = slot_live;
   assign out_chan  = slot_live ? oslot[CW-1:0] : '0;

endmodule

// File: rtl/tdm_wire_packer_chk.sv
module tdm_wire_packer_chk #(
   parameter int NUM_CH = 4,
   parameter int TDM    = 3,
   parameter int DW     = 16,
   localparam int NW  = tdm_pack_pkg::ceil_div(NUM_CH, TDM),
   localparam int CYC = tdm_pack_pkg::ceil_div(NUM_CH, NW),
   localparam int CW  = tdm_pack_pkg::width_of(CYC)
) (
   input logic             clk,
   input logic             rst,
   input logic             out_valid,
   input logic [NW*DW-1:0] out_data,
   input logic [CW-1:0]    out_chan
);

   int ck_os;

   always_ff @(posedge clk) begin
      if (rst) ck_os <= TDM - 1;
      else     ck_os <= (ck_os + 1) % TDM;
   end

   // R5: shared slot index follows the period position
   a_r5_chan_tracks_slot: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (int'(out_chan) == ck_os));

   // R4: idle slots carry nothing
   a_r4_idle_slot_quiet: assert property (@(posedge clk) disable iff (rst)
      (ck_os >= CYC) |-> (!out_valid && out_data == '0 && out_chan == '0));

   // R7: a period is either valid from slot 0 on or not at all
   a_r7_period_whole: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_chan != '0) |-> $past(out_valid));

   // R8: reset leaves no valid output behind
   a_r8_reset_clears: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && out_data == '0));

   // R9: padding slots on the last wire are zero
   a_r9_pad_zero: assert property (@(posedge clk) disable iff (rst)
      (out_valid && ((NW - 1) * CYC + int'(out_chan) >= NUM_CH))
      |-> (out_data[NW*DW-1 -: DW] == '0));

endmodule

bind tdm_wire_packer tdm_wire_packer_chk #(
   .NUM_CH (NUM_CH),
   .TDM    (TDM),
   .DW     (DW)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .out_valid (out_valid),
   .out_data  (out_data),
   .out_chan  (out_chan)
);

// File: tb/tdm_pack_harness.sv
`timescale 1ns/1ps
module tdm_pack_harness #(
   parameter int N  = 4,
   parameter int T  = 3,
   parameter int DW = 16
) (
   input  logic clk,
   output int   n_chk,
   output int   n_fail,
   output logic done
);

   localparam int W   = (N + T - 1) / T;
   localparam int C   = (N + W - 1) / W;
   localparam int CWB = (C <= 1) ? 1 : $clog2(C);

   logic            rst = 1'b1;
   logic            iv  = 1'b0;
   logic [N*DW-1:0] idat = '0;
   logic            ov;
   logic [W*DW-1:0] od;
   logic [CWB-1:0]  oc;

   tdm_wire_packer #(.NUM_CH(N), .TDM(T), .DW(DW)) u_tdm_wire_packer (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (iv),
      .in_data   (idat),
      .out_valid (ov),
      .out_data  (od),
      .out_chan  (oc)
   );

   // behavioural reference state
   int            mslot;
   int            moslot;
   bit            mact;
   logic [DW-1:0] mhold [N];
   bit            r6_mode;
   bit            r8_mode;

   task automatic check(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s N=%0d T=%0d %s: actual %0h expected %0h",
                  tag, N, T, what, act, exp);
      end
   endtask

   task automatic compare();
      bit    v;
      string tv;
      v  = mact && (moslot < C);
      tv = r8_mode ? "R8" : (!mact ? "R7" : ((moslot < C) ? "R2" : "R4"));
      check(tv, "out_valid", 64'(ov), 64'(v));
      check((W == 1) ? "R10" : "R5", "out_chan", 64'(oc), v ? 64'(moslot) : 64'd0);
      for (int w = 0; w < W; w++) begin
         int            idx;
         logic [DW-1:0] e;
         string         td;
         idx = w * C + moslot;
         e   = (v && idx < N) ? mhold[idx] : '0;
         td  = r6_mode ? "R6" : (r8_mode ? "R8" : ((idx >= N) ? "R9" :
               ((w == W - 1) ? "R1" : "R3")));
         check(td, $sformatf("wire%0d (R11 timing)", w),
               64'(od[w*DW +: DW]), 64'(e));
      end
   endtask

   task automatic step(input bit r, input bit v, input bit fresh);
      rst = r;
      iv  = v;
      if (fresh) begin
         for (int c = 0; c < N; c++) idat[c*DW +: DW] = DW'($urandom);
      end
      @(posedge clk);
      if (rst) begin
         mslot  = 0;
         moslot = T - 1;
         mact   = 0;
         for (int c = 0; c < N; c++) mhold[c] = '0;
      end else begin
         if (mslot == 0) begin
            mact = iv;
            if (iv) for (int c = 0; c < N; c++) mhold[c] = idat[c*DW +: DW];
         end
         moslot = mslot;
         mslot  = (mslot + 1) % T;
      end
      @(negedge clk);
      compare();
   endtask

   initial begin
      n_chk = 0; n_fail = 0; done = 1'b0;
      r6_mode = 0; r8_mode = 1;
      mslot = 0; moslot = T - 1; mact = 0;
      for (int c = 0; c < N; c++) mhold[c] = '0;
      @(negedge clk);
      step(1, 0, 0);
      step(1, 0, 0);
      check("R8", "reset out_valid", 64'(ov), 64'd0);
      check("R8", "reset out_chan", 64'(oc), 64'd0);
      r8_mode = 0;
      // R3: steady stream, data changes only at period start
      repeat (4 * T) step(0, 1, mslot == 0);
      // R7: no valid at any period start
      repeat (3 * T) step(0, 0, 1);
      // R6: inputs churn mid-period, valid random at the start
      r6_mode = 1;
      repeat (6 * T) step(0, (mslot != 0) ? 1'b1 : 1'($urandom % 2), 1);
      r6_mode = 0;
      // R8: reset asserted away from slot 0
      step(0, 1, 1);
      if (T > 1) step(0, 1, 0);
      r8_mode = 1;
      step(1, 1, 1);
      step(1, 1, 1);
      r8_mode = 0;
      repeat (5 * T) step(0, 1, mslot == 0);
      done = 1'b1;
   end

endmodule

// File: tb/tdm_wire_packer_bench.sv
`timescale 1ns/1ps
module tdm_wire_packer_bench;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   int   c_a, f_a, c_b, f_b, c_c, f_c, c_d, f_d;
   logic d_a, d_b, d_c, d_d;
   bit   reported = 0;

   // idle slots per period
   tdm_pack_harness #(.N(4), .T(3), .DW(16)) u_idle  (.clk(clk), .n_chk(c_a), .n_fail(f_a), .done(d_a));
   // padded last wire
   tdm_pack_harness #(.N(5), .T(3), .DW(12)) u_pad   (.clk(clk), .n_chk(c_b), .n_fail(f_b), .done(d_b));
   // single wire, true channel numbers
   tdm_pack_harness #(.N(4), .T(4), .DW(8))  u_one   (.clk(clk), .n_chk(c_c), .n_fail(f_c), .done(d_c));
   // unit TDM factor, one channel per wire
   tdm_pack_harness #(.N(4), .T(1), .DW(10)) u_unit  (.clk(clk), .n_chk(c_d), .n_fail(f_d), .done(d_d));

   task automatic report(input bit timed_out);
      int tot, bad;
      tot = c_a + c_b + c_c + c_d;
      bad = f_a + f_b + f_c + f_d;
      if (timed_out) begin
         tot++;
         bad++;
         $display("FAIL watchdog: actual not finished expected finished");
      end
      $display("%0d/%0d checks passed", tot - bad, tot);
      $finish;
   endtask

   initial begin
      wait (d_a === 1'b1 && d_b === 1'b1 && d_c === 1'b1 && d_d === 1'b1);
      @(negedge clk);
      if (!reported) begin
         reported = 1;
         report(0);
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!reported) begin
         reported = 1;
         report(1);
      end
   end

endmodule